// File: doc/BRIEF.md
# Serial Auto-Baud Boot Handshake Controller

This block works out the bit rate of a host UART at power-up and then confirms the link with a two-byte exchange. After reset it waits a fixed settle time. It then times the low phase of all-zero characters that the host keeps sending. The low phase of such a character is nine bit times long: the start bit and eight zero data bits. Several of these timings are averaged, and the average is turned into a bit-period reload value. That value is loaded into the divisor register.

With the divisor in place, the block sends one acknowledge byte of 0x00 at the new rate. It then waits for the host to answer with 0x55. A good answer locks the link: both serial enables drop, the TX line rests high, and the divisor stays available to the loader that follows. Any fault ends in a sticky error. A fault is a bad answer, a framing fault, a silent host, an over-long low phase or an unusably fast rate. Only a reset or a watchdog-overflow pulse clears the error and starts the sequence again.

Top module: `abh_boot_handshake`

## Requirements
- R1: After reset, and in the cycle after a `wdt_ovf_i` pulse, `tx_o`=1, `lock_o`=0, `err_o`=0, `divisor_o`=0, and `rxen_o`=`txen_o`=1.
- R2: Falling edges on `rx_i` within the first SETTLE_CYCLES (100) clock cycles after reset do not count as measurement samples.
- R3: `rx_i` passes through a two-flop synchronizer. Each low phase is counted in clock cycles. NUM_MEAS (4) accepted counts are averaged, and the bit period is round(average/9). `divisor_o` becomes that bit period minus one.
- R4: When a low count differs from the one before it by more than TOL (8) cycles, the samples gathered so far are discarded and collection restarts with this count as the first sample.
- R5: Once the divisor is loaded, `tx_o` sends exactly one 0x00 frame: a low start bit, eight data bits LSB first and a high stop bit, each lasting `divisor_o`+1 cycles.
- R6: A reply of 0x55 is sampled mid-bit at the new rate. A good reply, with a high stop bit, sets `lock_o`=1 and `rxen_o`=`txen_o`=0, leaves `tx_o` high and holds `divisor_o` unchanged.
- R7: A reply byte other than 0x55, or a reply whose stop bit samples low, sets `err_o`.
- R8: If no reply start bit appears within REPLY_BITS (32) bit periods after the acknowledge ends, `err_o` is set.
- R9: If a low phase reaches 2^CNT_W-1 cycles (65535 by default), `err_o` is set.
- R10: If the rounded bit period is below MIN_BIT (4) cycles, `err_o` is set and no acknowledge is sent.
- R11: `lock_o` and `err_o` stay set until reset. A `wdt_ovf_i` pulse clears them and restarts the settle and measure sequence, and a later measurement can lock again.
- R12: `lock_o` and `err_o` are never both high, and `tx_o` is high whenever no acknowledge frame is in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse, synchronous clear |
| rx_i | input | 1 | Serial receive line from the host (asynchronous) |
| tx_o | output | 1 | Serial transmit line to the host |
| divisor_o | output | CNT_W | Bit-period reload value (period minus one) |
| lock_o | output | 1 | Handshake completed, rate locked |
| err_o | output | 1 | Handshake failed, sticky |
| rxen_o | output | 1 | Receive enable, high while the handshake runs |
| txen_o | output | 1 | Transmit enable, high while the handshake runs |

## Verification
The assertions take three things for granted about the inputs:
- `rx_i` rests high when reset ends.
- The host stays quiet while the acknowledge is being sent.
- `wdt_ovf_i` arrives as a single-cycle pulse.

The stimulus keeps to these assumptions:
- It drives `rx_i` only on falling clock edges, and holds it high through reset.
- It waits for the whole acknowledge, plus one bit period, before it sends a reply.
- It uses low-phase lengths whose nearest-ninth rounding is never a tie.

Within these limits the sticky-flag, mutual-exclusion and divisor-hold properties can be checked cycle by cycle.

// File: rtl/abh_pkg.sv
package abh_pkg;

  typedef enum logic [2:0] {
    ST_SETTLE,
    ST_MEAS,
    ST_LOAD,
    ST_ACK,
    ST_REPLY,
    ST_DONE,
    ST_FAIL
  } abh_state_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } abh_rx_state_e;

  localparam logic [7:0] ACK_BYTE   = 8'h00;
  localparam logic [7:0] REPLY_BYTE = 8'h55;

  // nearest integer of cnt/9: low phase of an all-zero character spans 9 bits
  function automatic logic [31:0] abh_round_div9(input logic [31:0] cnt);
    return (cnt + 32'd4) / 32'd9;
  endfunction

  function automatic logic [31:0] abh_abs_diff(input logic [31:0] a, input logic [31:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

endpackage

// File: rtl/abh_sync.sv
module abh_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic fall,
  output logic rise
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign dout = s2_q;
  assign fall = s3_q & ~s2_q;
  assign rise = ~s3_q & s2_q;

endmodule

// File: rtl/abh_meas.sv
module abh_meas
  import abh_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int AVG_LOG2 = 2,
  parameter int TOL      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             rx_fall,
  input  logic             rx_rise,
  output logic [CNT_W-1:0] avg_o,
  output logic             avg_valid_o,
  output logic             ovf_o,
  output logic             smp_o
);
  localparam int NUM_MEAS = 1 << AVG_LOG2;
  localparam int SUM_W    = CNT_W + AVG_LOG2;
  localparam int IDX_W    = AVG_LOG2 + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] low_q, prev_q;
  logic [SUM_W-1:0] sum_q;
  logic [IDX_W-1:0] n_q;
  logic             on_q, fin_q;
  logic             far;

  assign far   = abh_abs_diff(32'(low_q), 32'(prev_q)) > 32'(TOL);
  assign smp_o = en && on_q && rx_rise;
  assign ovf_o = en && on_q && !rx_rise && (low_q == CNT_MAX);
  assign avg_o = CNT_W'(sum_q >> AVG_LOG2);
  assign avg_valid_o = fin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0; prev_q <= '0; sum_q <= '0; n_q <= '0; on_q <= 1'b0; fin_q <= 1'b0;
    end else if (clr || !en) begin
      low_q <= '0; prev_q <= '0; sum_q <= '0; n_q <= '0; on_q <= 1'b0; fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (rx_fall) begin
        on_q  <= 1'b1;
        low_q <= CNT_W'(1);
      end else if (on_q) begin
        if (rx_rise) begin
          on_q   <= 1'b0;
          prev_q <= low_q;
          if (n_q == '0 || far) begin
            sum_q <= SUM_W'(low_q);
            n_q   <= IDX_W'(1);
            fin_q <= (NUM_MEAS == 1);
          end else begin
            sum_q <= sum_q + SUM_W'(low_q);
            n_q   <= n_q + IDX_W'(1);
            fin_q <= (n_q == IDX_W'(NUM_MEAS - 1));
          end
        end else if (low_q == CNT_MAX) begin
          on_q <= 1'b0;
        end else begin
          low_q <= low_q + CNT_W'(1);
        end
      end
    end
  end

  p_sample_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    n_q <= IDX_W'(NUM_MEAS));
  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_o && far && n_q != '0 && !clr) |=> (n_q == IDX_W'(1)));

endmodule

// File: rtl/abh_tx.sv
module abh_tx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic [7:0]       data,
  input  logic [DIV_W-1:0] div,
  output logic             tx,
  output logic             busy,
  output logic             done
);
  logic [9:0]       shf_q;
  logic [3:0]       idx_q;
  logic [DIV_W-1:0] cyc_q;
  logic             busy_q, tx_q;

  assign tx   = tx_q;
  assign busy = busy_q;
  assign done = busy_q && (cyc_q == '0) && (idx_q == 4'd9);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shf_q <= '1; idx_q <= '0; cyc_q <= '0; busy_q <= 1'b0; tx_q <= 1'b1;
    end else if (clr) begin
      shf_q <= '1; idx_q <= '0; cyc_q <= '0; busy_q <= 1'b0; tx_q <= 1'b1;
    end else if (!busy_q) begin
      if (start) begin
        shf_q  <= {1'b1, data, 1'b0};
        tx_q   <= 1'b0;
        cyc_q  <= div;
        idx_q  <= '0;
        busy_q <= 1'b1;
      end
    end else if (cyc_q == '0) begin
      if (idx_q == 4'd9) begin
        busy_q <= 1'b0;
        tx_q   <= 1'b1;
      end else begin
        idx_q <= idx_q + 4'd1;
        tx_q  <= shf_q[1];
        shf_q <= {1'b1, shf_q[9:1]};
        cyc_q <= div;
      end
    end else begin
      cyc_q <= cyc_q - DIV_W'(1);
    end
  end

  p_start_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
  p_frame_ends_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> (tx && !busy));

endmodule

// File: rtl/abh_rx.sv
module abh_rx
  import abh_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             rx_s,
  input  logic             rx_fall,
  input  logic [DIV_W-1:0] div,
  output logic             busy,
  output logic             done,
  output logic [7:0]       data,
  output logic             ferr
);
  abh_rx_state_e    st_q;
  logic [DIV_W-1:0] cnt_q;
  logic [2:0]       idx_q;
  logic [7:0]       dat_q;

  assign busy = (st_q != RX_IDLE);
  assign done = (st_q == RX_STOP) && (cnt_q == '0);
  assign ferr = done && !rx_s;
  assign data = dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RX_IDLE; cnt_q <= '0; idx_q <= '0; dat_q <= '0;
    end else if (!arm) begin
      st_q <= RX_IDLE; cnt_q <= '0; idx_q <= '0;
    end else begin
      case (st_q)
        RX_IDLE: if (rx_fall) begin
          st_q  <= RX_START;
          cnt_q <= div >> 1;
        end
        RX_START: if (cnt_q == '0) begin
          if (rx_s) st_q <= RX_IDLE;
          else begin
            st_q  <= RX_DATA;
            cnt_q <= div;
            idx_q <= '0;
          end
        end else cnt_q <= cnt_q - DIV_W'(1);
        RX_DATA: if (cnt_q == '0) begin
          dat_q <= {rx_s, dat_q[7:1]};
          cnt_q <= div;
          idx_q <= idx_q + 3'd1;
          if (idx_q == 3'd7) st_q <= RX_STOP;
        end else cnt_q <= cnt_q - DIV_W'(1);
        RX_STOP: if (cnt_q == '0) st_q <= RX_IDLE;
                 else cnt_q <= cnt_q - DIV_W'(1);
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  p_done_needs_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> arm);

endmodule

// File: rtl/abh_boot_handshake.sv
module abh_boot_handshake
  import abh_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int AVG_LOG2      = 2,
  parameter int SETTLE_CYCLES = 100,
  parameter int TOL           = 8,
  parameter int REPLY_BITS    = 32,
  parameter int MIN_BIT       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wdt_ovf_i,
  input  logic             rx_i,
  output logic             tx_o,
  output logic [CNT_W-1:0] divisor_o,
  output logic             lock_o,
  output logic             err_o,
  output logic             rxen_o,
  output logic             txen_o
);
  localparam int SCNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam int RB_W   = $clog2(REPLY_BITS + 1);

  abh_state_e       st_q;
  logic [SCNT_W-1:0] settle_q;
  logic [CNT_W-1:0] div_q, to_cyc_q;
  logic [RB_W-1:0]  to_bits_q;

  // named internal events
  logic rx_s, rx_fall, rx_rise;
  logic [CNT_W-1:0] avg;
  logic avg_valid, meas_ovf, meas_smp;
  logic tx_start, tx_busy, tx_done;
  logic rx_busy, rx_done, rx_ferr;
  logic [7:0] rx_data;
  logic [31:0] bp32;
  logic bp_ok, reply_ok, reply_to;

  abh_sync u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_i),
    .dout(rx_s), .fall(rx_fall), .rise(rx_rise)
  );

  abh_meas #(.CNT_W(CNT_W), .AVG_LOG2(AVG_LOG2), .TOL(TOL)) u_meas (
    .clk(clk), .rst_n(rst_n), .clr(wdt_ovf_i), .en(st_q == ST_MEAS),
    .rx_fall(rx_fall), .rx_rise(rx_rise),
    .avg_o(avg), .avg_valid_o(avg_valid), .ovf_o(meas_ovf), .smp_o(meas_smp)
  );

  abh_tx #(.DIV_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(wdt_ovf_i), .start(tx_start),
    .data(ACK_BYTE), .div(div_q), .tx(tx_o), .busy(tx_busy), .done(tx_done)
  );

  abh_rx #(.DIV_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .arm((st_q == ST_REPLY) && !wdt_ovf_i),
    .rx_s(rx_s), .rx_fall(rx_fall), .div(div_q),
    .busy(rx_busy), .done(rx_done), .data(rx_data), .ferr(rx_ferr)
  );

  assign bp32     = abh_round_div9(32'(avg));
  assign bp_ok    = bp32 >= 32'(MIN_BIT);
  assign tx_start = (st_q == ST_LOAD);
  assign reply_ok = (rx_data == REPLY_BYTE) && !rx_ferr;
  assign reply_to = (st_q == ST_REPLY) && !rx_busy && (to_bits_q == RB_W'(REPLY_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_SETTLE; settle_q <= '0; div_q <= '0; to_cyc_q <= '0; to_bits_q <= '0;
    end else if (wdt_ovf_i) begin
      st_q <= ST_SETTLE; settle_q <= '0; div_q <= '0; to_cyc_q <= '0; to_bits_q <= '0;
    end else begin
      case (st_q)
        ST_SETTLE:
          if (settle_q == SCNT_W'(SETTLE_CYCLES - 1)) st_q <= ST_MEAS;
          else settle_q <= settle_q + SCNT_W'(1);
        ST_MEAS:
          if (meas_ovf) st_q <= ST_FAIL;
          else if (avg_valid) begin
            if (bp_ok) begin
              div_q <= CNT_W'(bp32 - 32'd1);
              st_q  <= ST_LOAD;
            end else st_q <= ST_FAIL;
          end
        ST_LOAD: st_q <= ST_ACK;
        ST_ACK:
          if (tx_done) begin
            st_q      <= ST_REPLY;
            to_cyc_q  <= div_q;
            to_bits_q <= '0;
          end
        ST_REPLY:
          if (rx_done) st_q <= reply_ok ? ST_DONE : ST_FAIL;
          else if (reply_to) st_q <= ST_FAIL;
          else if (!rx_busy) begin
            if (to_cyc_q == '0) begin
              to_cyc_q  <= div_q;
              to_bits_q <= to_bits_q + RB_W'(1);
            end else to_cyc_q <= to_cyc_q - CNT_W'(1);
          end
        default: st_q <= st_q;
      endcase
    end
  end

  assign divisor_o = div_q;
  assign lock_o    = (st_q == ST_DONE);
  assign err_o     = (st_q == ST_FAIL);
  assign rxen_o    = !(lock_o || err_o);
  assign txen_o    = !(lock_o || err_o);

  p_lock_err_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(lock_o && err_o));
  p_tx_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_ACK) |-> tx_o);
  p_lock_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !wdt_ovf_i) |=> lock_o);
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !wdt_ovf_i) |=> err_o);
  p_wdt_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_ovf_i |=> (!lock_o && !err_o && divisor_o == '0));
  p_div_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !wdt_ovf_i) |=> $stable(divisor_o));
  p_lock_enables_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |-> (!rxen_o && !txen_o));
  p_settle_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_MEAS) && $past(st_q == ST_SETTLE) && !$past(wdt_ovf_i))
      |-> ($past(settle_q) == SCNT_W'(SETTLE_CYCLES - 1)));
  p_no_sample_settle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SETTLE) |-> !meas_smp);
  p_ovf_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_ovf && !wdt_ovf_i) |=> err_o);
  p_bad_reply_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_REPLY) && rx_done && !reply_ok && !wdt_ovf_i) |=> err_o);
  p_min_period_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |-> (32'(divisor_o) >= 32'(MIN_BIT - 1)));

endmodule

// File: tb/tb_abh_boot_handshake.sv
module tb_abh_boot_handshake;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wdt = 1'b0;
  logic rx = 1'b1;
  logic tx;
  logic [15:0] divisor;
  logic lock, err, rxen, txen;

  int checks = 0;
  int errors = 0;
  int ack_seen = 0;
  int mon_p = 16;
  logic [7:0] exp_q[$];
  logic [7:0] mon_v;
  logic mon_start, mon_stop;

  always #(CLK_PERIOD/2) clk = ~clk;

  abh_boot_handshake dut (
    .clk(clk), .rst_n(rst_n), .wdt_ovf_i(wdt), .rx_i(rx), .tx_o(tx),
    .divisor_o(divisor), .lock_o(lock), .err_o(err), .rxen_o(rxen), .txen_o(txen)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_bp(int low_len);
    return int'(real'(low_len) / 9.0);
  endfunction

  // monitor: decodes frames on tx and compares against the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && tx === 1'b0) begin
        repeat (mon_p/2) @(negedge clk);
        mon_start = tx;
        for (int i = 0; i < 8; i++) begin
          repeat (mon_p) @(negedge clk);
          mon_v[i] = tx;
        end
        repeat (mon_p) @(negedge clk);
        mon_stop = tx;
        if (exp_q.size() == 0) begin
          chk("R5", "unexpected tx frame", 1, 0);
        end else begin
          chk("R5", "ack byte", mon_v, exp_q.pop_front());
          chk("R5", "ack start/stop", {mon_start, mon_stop}, 2'b01);
        end
        ack_seen++;
      end
    end
  end

  task automatic do_reset();
    rx = 1'b1; wdt = 1'b0; rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse_wdt();
    wdt = 1'b1; @(negedge clk); wdt = 1'b0;
  endtask

  task automatic send_zero(int low_len, int p);
    rx = 1'b0;
    repeat (low_len) @(negedge clk);
    rx = 1'b1;
    repeat (2*p) @(negedge clk);
  endtask

  task automatic send_frame(logic [7:0] b, int p, logic stop);
    rx = 1'b0; repeat (p) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i]; repeat (p) @(negedge clk);
    end
    rx = stop; repeat (p) @(negedge clk);
    rx = 1'b1; repeat (2*p) @(negedge clk);
  endtask

  task automatic wait_ack(int n);
    while (ack_seen < n) @(negedge clk);
  endtask

  // driver: measure with four equal characters, expect ack, then wait past it
  task automatic measure_ack(int low_len);
    int n;
    n = ack_seen;
    mon_p = exp_bp(low_len);
    exp_q.push_back(8'h00);
    for (int i = 0; i < 4; i++) send_zero(low_len, mon_p);
    wait_ack(n + 1);
    repeat (mon_p + 2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk("R1", "tx idle", tx, 1);
    chk("R1", "lock", lock, 0);
    chk("R1", "err", err, 0);
    chk("R1", "divisor", divisor, 0);
    chk("R1", "enables", {rxen, txen}, 2'b11);

    // R3 R5 R6 normal lock at period 16
    repeat (110) @(negedge clk);
    measure_ack(144);
    chk("R3", "divisor p16", divisor, 15);
    chk("R6", "lock before reply", lock, 0);
    send_frame(8'h55, 16, 1'b1);
    chk("R6", "lock", lock, 1);
    chk("R12", "err with lock", err, 0);
    chk("R6", "enables cleared", {rxen, txen}, 2'b00);
    chk("R6", "tx high", tx, 1);
    repeat (50) @(negedge clk);
    chk("R6", "divisor held", divisor, 15);
    chk("R11", "lock sticky", lock, 1);

    // R11 watchdog clears, then relock at period 12
    pulse_wdt();
    chk("R1", "wdt lock", lock, 0);
    chk("R1", "wdt divisor", divisor, 0);
    chk("R1", "wdt enables", {rxen, txen}, 2'b11);
    repeat (110) @(negedge clk);
    measure_ack(108);
    send_frame(8'h55, 12, 1'b1);
    chk("R11", "relock after wdt", lock, 1);
    chk("R3", "divisor p12", divisor, 11);

    // R2 early edge in settle window is ignored
    do_reset();
    repeat (5) @(negedge clk);
    send_zero(72, 0);
    repeat (40) @(negedge clk);
    mon_p = 8;
    for (int i = 0; i < 3; i++) send_zero(72, 8);
    repeat (40) @(negedge clk);
    chk("R2", "no ack after three chars", exp_q.size() + ack_seen, ack_seen);
    chk("R2", "tx still idle", tx, 1);
    begin
      int n0;
      n0 = ack_seen;
      exp_q.push_back(8'h00);
      send_zero(72, 8);
      wait_ack(n0 + 1);
      repeat (10) @(negedge clk);
    end
    chk("R2", "divisor p8", divisor, 7);
    send_frame(8'h55, 8, 1'b1);
    chk("R2", "lock p8", lock, 1);

    // R3 rounding: 113/9 = 12.56 -> period 13
    do_reset();
    repeat (110) @(negedge clk);
    measure_ack(113);
    chk("R3", "rounded divisor", divisor, 12);
    send_frame(8'h55, 13, 1'b1);
    chk("R3", "lock p13", lock, 1);

    // R4 tolerance restart: 112 112 150 | 112 116 112 108
    do_reset();
    repeat (110) @(negedge clk);
    begin
      int n0;
      n0 = ack_seen;
      mon_p = 12;
      send_zero(112, 12); send_zero(112, 12); send_zero(150, 12);
      chk("R4", "no ack after outlier", ack_seen, n0);
      exp_q.push_back(8'h00);
      send_zero(112, 12); send_zero(116, 12); send_zero(112, 12); send_zero(108, 12);
      wait_ack(n0 + 1);
      repeat (14) @(negedge clk);
    end
    chk("R4", "divisor after restart", divisor, 11);
    send_frame(8'h55, 12, 1'b1);
    chk("R4", "lock after restart", lock, 1);

    // R7 wrong reply byte
    do_reset();
    repeat (110) @(negedge clk);
    measure_ack(144);
    send_frame(8'h54, 16, 1'b1);
    chk("R7", "wrong byte err", err, 1);
    chk("R12", "lock with err", lock, 0);
    chk("R7", "enables after err", {rxen, txen}, 2'b00);
    repeat (30) @(negedge clk);
    chk("R11", "err sticky", err, 1);
    pulse_wdt();
    chk("R11", "wdt clears err", err, 0);

    // R7 framing error
    do_reset();
    repeat (110) @(negedge clk);
    measure_ack(144);
    send_frame(8'h55, 16, 1'b0);
    chk("R7", "framing err", err, 1);
    chk("R7", "framing no lock", lock, 0);

    // R8 reply timeout
    do_reset();
    repeat (110) @(negedge clk);
    measure_ack(144);
    repeat (20*16) @(negedge clk);
    chk("R8", "err before timeout", err, 0);
    repeat (25*16) @(negedge clk);
    chk("R8", "err after timeout", err, 1);

    // R10 too fast: 31/9 rounds to 3 < 4
    do_reset();
    repeat (110) @(negedge clk);
    begin
      int n0;
      n0 = ack_seen;
      mon_p = 4;
      for (int i = 0; i < 4; i++) send_zero(31, 4);
      repeat (60) @(negedge clk);
      chk("R10", "fast err", err, 1);
      chk("R10", "no ack", ack_seen, n0);
      chk("R10", "tx idle", tx, 1);
    end

    // R9 overflow of low counter
    do_reset();
    repeat (110) @(negedge clk);
    rx = 1'b0;
    repeat (65000) @(negedge clk);
    chk("R9", "no err before limit", err, 0);
    repeat (545) @(negedge clk);
    chk("R9", "overflow err", err, 1);
    rx = 1'b1;
    repeat (20) @(negedge clk);
    chk("R9", "err holds", err, 1);
    chk("R5", "scoreboard drained", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule